// File: doc/BRIEF.md
# Serial FIFO Status and Interrupt Unit

This block sits between a register bus and a serial shift engine. It holds a transmit queue and a receive queue, each a first-in first-out store of 16 characters. It turns their fill levels and receive conditions into one status word, and masks that word into a single interrupt line. The bus side writes characters for transmission and reads received characters. The engine side takes characters to send through a pop handshake and delivers received characters, with their parity and framing error flags, through a push handshake.

A bit-time tick from the engine drives a receive idle timer. When characters wait in the receive queue and none arrives or leaves for the programmed number of bit times, a timeout flag is raised. Separate flush strobes empty either queue at once. Status and interrupt are registered: each follows the internal state one clock later.

Top module: `serial_fifo_irq`

## Requirements
- R1: After synchronous reset the status word reads 0x006 (bit 1 transmit empty and bit 2 transmit half-empty set, all others clear) and `irq` is low.
- R2: The transmit queue holds 16 characters and sends them to `eng_tx_data` in write order, one per `eng_tx_pop`. Status bit 1 is set when it is empty, bit 2 when it holds at most 8 entries, and bit 9 when it holds 16.
- R3: A bus write to the transmit queue while it holds 16 entries is ignored: the character is never sent and the fill level is unchanged.
- R4: The receive queue holds 16 characters returned on `bus_rx_data` in arrival order, one per `bus_rx_rd`. Status bit 0 is set while it is not empty, and bit 8 while it holds at least 8 entries.
- R5: An engine push while the receive queue holds 16 entries drops the character and sets status bit 5 (overrun). The flag clears when the bus reads an entry, or on a receive flush.
- R6: Status bit 3 shows the parity error flag and bit 4 the framing error flag of the character at the head of the receive queue. Both read 0 when the queue is empty.
- R7: While the receive queue is not empty, an idle counter counts `bit_tick` pulses. It restarts on every push or read. Status bit 7 is set once the count reaches `rx_tmo_val`, and clears on the next push, read or flush. A value of 0 disables the timeout.
- R8: A `tx_flush` or `rx_flush` pulse empties the matching queue in that clock and leaves the other queue untouched.
- R9: `irq` is the OR of status bits 0 to 8, each ANDed with the same bit of `int_enable`. Bit 6 is reserved and always reads 0, so enabling it never raises `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_tx_wr | input | 1 | Write pulse for the transmit data port |
| bus_tx_data | input | DW | Character to queue for transmission |
| bus_rx_rd | input | 1 | Read pulse for the receive data port; removes the head entry |
| bus_rx_data | output | DW | Character at the head of the receive queue |
| tx_flush | input | 1 | Empties the transmit queue |
| rx_flush | input | 1 | Empties the receive queue and clears overrun |
| rx_tmo_val | input | TW | Idle timeout in bit times; 0 disables it |
| int_enable | input | 9 | Interrupt mask, same bit positions as status bits 0 to 8 |
| eng_tx_pop | input | 1 | Engine takes the head transmit character |
| eng_tx_data | output | DW | Head transmit character |
| eng_tx_avail | output | 1 | Transmit queue is not empty |
| eng_rx_push | input | 1 | Engine delivers a received character |
| eng_rx_data | input | DW | Received character |
| eng_rx_perr | input | 1 | Parity error flag for the received character |
| eng_rx_ferr | input | 1 | Framing error flag for the received character |
| bit_tick | input | 1 | One pulse per serial bit time |
| status | output | 10 | Registered status word |
| irq | output | 1 | Registered interrupt request |

## Verification
On every cycle, the bound checker enforces several rules. The transmit empty and full flags are never set together, and empty always implies half-empty. A write to a full transmit queue leaves the fill level at 16. A dropped receive character sets overrun, and a read clears it. A flush leaves the queue empty. A raised `irq` always has an enabled status bit behind it, and reserved bit 6 stays clear. Other behaviour needs the directed scenarios. These cover the order in which characters leave each queue, the exact half-level thresholds, and that a dropped or ignored character never appears. They also cover the head-entry error flags moving as entries are read, and the exact tick count at which the timeout fires, including restart on a new arrival and the disabled setting.

// File: rtl/serial_fifo_irq_pkg.sv
package serial_fifo_irq_pkg;
  localparam int ST_W  = 10;
  localparam int IE_W  = 9;

  localparam int ST_RX_AVAIL = 0;
  localparam int ST_TX_EMPTY = 1;
  localparam int ST_TX_HALF  = 2;
  localparam int ST_RX_PERR  = 3;
  localparam int ST_RX_FERR  = 4;
  localparam int ST_RX_OVR   = 5;
  localparam int ST_RSVD     = 6;
  localparam int ST_RX_TMO   = 7;
  localparam int ST_RX_HALF  = 8;
  localparam int ST_TX_FULL  = 9;

  typedef logic [ST_W-1:0] status_t;
  typedef logic [IE_W-1:0] irq_mask_t;

  localparam status_t ST_RESET = status_t'((1 << ST_TX_EMPTY) | (1 << ST_TX_HALF));
endpackage

// File: rtl/sfq_fifo.sv
module sfq_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 16,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic          push,
  input  logic [W-1:0]  wdata,
  input  logic          pop,
  output logic [W-1:0]  rdata,
  output logic [CW-1:0] count,
  output logic          empty,
  output logic          full
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [CW-1:0] FULLC = CW'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] cnt;
  logic          do_push, do_pop;

  assign empty   = (cnt == '0);
  assign full    = (cnt == FULLC);
  assign do_push = push & ~full & ~flush;
  assign do_pop  = pop & ~empty & ~flush;

  // storage without reset so it maps onto distributed RAM
  always_ff @(posedge clk) begin
    if (do_push) mem[wptr] <= wdata;
  end

  assign rdata = mem[rptr];
  assign count = cnt;

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
    end else begin
      if (do_push) wptr <= (wptr == LAST) ? '0 : wptr + 1'b1;
      if (do_pop)  rptr <= (rptr == LAST) ? '0 : rptr + 1'b1;
      cnt <= cnt + CW'(do_push) - CW'(do_pop);
    end
  end
endmodule

// File: rtl/sfq_idle_timer.sv
module sfq_idle_timer #(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          restart,
  input  logic          active,
  input  logic          tick,
  input  logic [TW-1:0] limit,
  output logic          expired
);
  logic [TW-1:0] cnt;
  logic          exp_q;
  logic [TW:0]   next_cnt;

  assign next_cnt = {1'b0, cnt} + 1'b1;
  assign expired  = exp_q;

  always_ff @(posedge clk) begin
    if (rst || restart || !active) begin
      cnt   <= '0;
      exp_q <= 1'b0;
    end else if (tick && !exp_q && (limit != '0)) begin
      if (next_cnt == {1'b0, limit}) begin
        exp_q <= 1'b1;
        cnt   <= '0;
      end else begin
        cnt <= next_cnt[TW-1:0];
      end
    end
  end
endmodule

// File: rtl/sfq_status_irq.sv
module sfq_status_irq
  import serial_fifo_irq_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] tx_cnt,
  input  logic [CW-1:0] rx_cnt,
  input  logic          head_perr,
  input  logic          head_ferr,
  input  logic          ovr,
  input  logic          tmo,
  input  irq_mask_t     en,
  output status_t       status_q,
  output logic          irq_q
);
  localparam logic [CW-1:0] HALF  = CW'(DEPTH / 2);
  localparam logic [CW-1:0] FULLC = CW'(DEPTH);

  status_t   sts_d;
  irq_mask_t gated;
  logic      rx_any;

  assign rx_any = (rx_cnt != '0);

  always_comb begin
    sts_d              = '0;
    sts_d[ST_RX_AVAIL] = rx_any;
    sts_d[ST_TX_EMPTY] = (tx_cnt == '0);
    sts_d[ST_TX_HALF]  = (tx_cnt <= HALF);
    sts_d[ST_RX_PERR]  = rx_any & head_perr;
    sts_d[ST_RX_FERR]  = rx_any & head_ferr;
    sts_d[ST_RX_OVR]   = ovr;
    sts_d[ST_RSVD]     = 1'b0;
    sts_d[ST_RX_TMO]   = tmo;
    sts_d[ST_RX_HALF]  = (rx_cnt >= HALF);
    sts_d[ST_TX_FULL]  = (tx_cnt == FULLC);
  end

  for (genvar b = 0; b < IE_W; b++) begin : g_mask
    assign gated[b] = sts_d[b] & en[b];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      status_q <= ST_RESET;
      irq_q    <= 1'b0;
    end else begin
      status_q <= sts_d;
      irq_q    <= |gated;
    end
  end
endmodule

// File: rtl/serial_fifo_irq.sv
module serial_fifo_irq
  import serial_fifo_irq_pkg::*;
#(
  parameter int DW    = 8,
  parameter int DEPTH = 16,
  parameter int TW    = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_tx_wr,
  input  logic [DW-1:0] bus_tx_data,
  input  logic          bus_rx_rd,
  output logic [DW-1:0] bus_rx_data,
  input  logic          tx_flush,
  input  logic          rx_flush,
  input  logic [TW-1:0] rx_tmo_val,
  input  logic [8:0]    int_enable,
  input  logic          eng_tx_pop,
  output logic [DW-1:0] eng_tx_data,
  output logic          eng_tx_avail,
  input  logic          eng_rx_push,
  input  logic [DW-1:0] eng_rx_data,
  input  logic          eng_rx_perr,
  input  logic          eng_rx_ferr,
  input  logic          bit_tick,
  output logic [9:0]    status,
  output logic          irq
);
  localparam int CW  = $clog2(DEPTH + 1);
  localparam int RXW = DW + 2;

  logic [CW-1:0]  tx_cnt, rx_cnt;
  logic           tx_empty, tx_full, rx_empty, rx_full;
  logic [RXW-1:0] rx_head;
  logic           rx_ovr_q;
  logic           rx_read, rx_drop, tmo_restart, tmo_flag;
  status_t        status_q;
  logic           irq_q;

  sfq_fifo #(.W(DW), .DEPTH(DEPTH)) u_txq (
    .clk   (clk),
    .rst   (rst),
    .flush (tx_flush),
    .push  (bus_tx_wr),
    .wdata (bus_tx_data),
    .pop   (eng_tx_pop),
    .rdata (eng_tx_data),
    .count (tx_cnt),
    .empty (tx_empty),
    .full  (tx_full)
  );

  sfq_fifo #(.W(RXW), .DEPTH(DEPTH)) u_rxq (
    .clk   (clk),
    .rst   (rst),
    .flush (rx_flush),
    .push  (eng_rx_push),
    .wdata ({eng_rx_perr, eng_rx_ferr, eng_rx_data}),
    .pop   (bus_rx_rd),
    .rdata (rx_head),
    .count (rx_cnt),
    .empty (rx_empty),
    .full  (rx_full)
  );

  assign eng_tx_avail = ~tx_empty;
  assign bus_rx_data  = rx_head[DW-1:0];

  assign rx_read = bus_rx_rd & ~rx_empty;
  assign rx_drop = eng_rx_push & rx_full & ~rx_flush;

  // overrun: a drop in the same cycle as a read wins
  always_ff @(posedge clk) begin
    if (rst || rx_flush)  rx_ovr_q <= 1'b0;
    else if (rx_drop)     rx_ovr_q <= 1'b1;
    else if (rx_read)     rx_ovr_q <= 1'b0;
  end

  assign tmo_restart = eng_rx_push | rx_read | rx_flush;

  sfq_idle_timer #(.TW(TW)) u_tmo (
    .clk     (clk),
    .rst     (rst),
    .restart (tmo_restart),
    .active  (~rx_empty),
    .tick    (bit_tick),
    .limit   (rx_tmo_val),
    .expired (tmo_flag)
  );

  sfq_status_irq #(.DEPTH(DEPTH)) u_sts (
    .clk       (clk),
    .rst       (rst),
    .tx_cnt    (tx_cnt),
    .rx_cnt    (rx_cnt),
    .head_perr (rx_head[RXW-1]),
    .head_ferr (rx_head[RXW-2]),
    .ovr       (rx_ovr_q),
    .tmo       (tmo_flag),
    .en        (irq_mask_t'(int_enable)),
    .status_q  (status_q),
    .irq_q     (irq_q)
  );

  assign status = status_q;
  assign irq    = irq_q;
endmodule

// File: rtl/serial_fifo_irq_chk.sv
module serial_fifo_irq_chk #(
  parameter int DEPTH = 16,
  parameter int CW    = 5
) (
  input logic          clk,
  input logic          rst,
  input logic          bus_tx_wr,
  input logic          eng_tx_pop,
  input logic          tx_flush,
  input logic          eng_rx_push,
  input logic          bus_rx_rd,
  input logic          rx_flush,
  input logic [CW-1:0] tx_cnt,
  input logic [CW-1:0] rx_cnt,
  input logic          rx_ovr_q,
  input logic [9:0]    status,
  input logic          irq,
  input logic [8:0]    int_enable
);
  localparam logic [CW-1:0] FULLC = CW'(DEPTH);

  assert_tx_flags_excl_R2: assert property (@(posedge clk) disable iff (rst)
    !(status[9] && status[1]));

  assert_empty_is_half_R2: assert property (@(posedge clk) disable iff (rst)
    status[1] |-> status[2]);

  assert_full_write_ignored_R3: assert property (@(posedge clk) disable iff (rst)
    (bus_tx_wr && !eng_tx_pop && !tx_flush && tx_cnt == FULLC) |=> (tx_cnt == FULLC));

  assert_drop_sets_overrun_R5: assert property (@(posedge clk) disable iff (rst)
    (eng_rx_push && !rx_flush && rx_cnt == FULLC) |=> rx_ovr_q);

  assert_read_clears_overrun_R5: assert property (@(posedge clk) disable iff (rst)
    (bus_rx_rd && rx_cnt != '0 && !eng_rx_push) |=> !rx_ovr_q);

  assert_tx_flush_empties_R8: assert property (@(posedge clk) disable iff (rst)
    tx_flush |=> (tx_cnt == '0));

  assert_rx_flush_empties_R8: assert property (@(posedge clk) disable iff (rst)
    rx_flush |=> (rx_cnt == '0));

  assert_irq_has_source_R9: assert property (@(posedge clk) disable iff (rst)
    irq |-> ((status[8:0] & $past(int_enable)) != '0));

  assert_reserved_clear_R9: assert property (@(posedge clk) disable iff (rst)
    !status[6]);
endmodule

bind serial_fifo_irq serial_fifo_irq_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .bus_tx_wr   (bus_tx_wr),
  .eng_tx_pop  (eng_tx_pop),
  .tx_flush    (tx_flush),
  .eng_rx_push (eng_rx_push),
  .bus_rx_rd   (bus_rx_rd),
  .rx_flush    (rx_flush),
  .tx_cnt      (tx_cnt),
  .rx_cnt      (rx_cnt),
  .rx_ovr_q    (rx_ovr_q),
  .status      (status),
  .irq         (irq),
  .int_enable  (int_enable)
);

// File: tb/tb_serial_fifo_irq.sv
module tb_serial_fifo_irq;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_tx_wr = 1'b0;
  logic [7:0] bus_tx_data = '0;
  logic       bus_rx_rd = 1'b0;
  logic [7:0] bus_rx_data;
  logic       tx_flush = 1'b0;
  logic       rx_flush = 1'b0;
  logic [7:0] rx_tmo_val = '0;
  logic [8:0] int_enable = '0;
  logic       eng_tx_pop = 1'b0;
  logic [7:0] eng_tx_data;
  logic       eng_tx_avail;
  logic       eng_rx_push = 1'b0;
  logic [7:0] eng_rx_data = '0;
  logic       eng_rx_perr = 1'b0;
  logic       eng_rx_ferr = 1'b0;
  logic       bit_tick = 1'b0;
  logic [9:0] status;
  logic       irq;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_P/2) clk = ~clk;

  serial_fifo_irq dut (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  task automatic bus_write(input logic [7:0] d);
    bus_tx_wr = 1'b1; bus_tx_data = d;
    @(negedge clk);
    bus_tx_wr = 1'b0;
  endtask

  task automatic tx_take();
    eng_tx_pop = 1'b1;
    @(negedge clk);
    eng_tx_pop = 1'b0;
  endtask

  task automatic eng_push(input logic [7:0] d, input logic pe, input logic fe);
    eng_rx_push = 1'b1; eng_rx_data = d; eng_rx_perr = pe; eng_rx_ferr = fe;
    @(negedge clk);
    eng_rx_push = 1'b0; eng_rx_perr = 1'b0; eng_rx_ferr = 1'b0;
  endtask

  task automatic bus_read();
    bus_rx_rd = 1'b1;
    @(negedge clk);
    bus_rx_rd = 1'b0;
  endtask

  task automatic tick();
    bit_tick = 1'b1;
    @(negedge clk);
    bit_tick = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    check("R1 status", 32'(status), 32'h006);
    check("R1 irq", 32'(irq), 0);
  endtask

  task automatic t_tx();
    for (int i = 0; i < 8; i++) bus_write(8'h40 + 8'(i));
    settle();
    check("R2 half-empty at 8", 32'(status[2]), 1);
    check("R2 not empty", 32'(status[1]), 0);
    bus_write(8'h48);
    settle();
    check("R2 half-empty clear at 9", 32'(status[2]), 0);
    for (int i = 9; i < 16; i++) bus_write(8'h40 + 8'(i));
    settle();
    check("R2 full at 16", 32'(status[9]), 1);
    bus_write(8'hEE);
    settle();
    check("R3 still full after extra write", 32'(status[9]), 1);
    for (int i = 0; i < 16; i++) begin
      check("R2 tx order", 32'(eng_tx_data), 32'(8'h40 + 8'(i)));
      tx_take();
    end
    settle();
    check("R3 ignored char never sent", 32'(eng_tx_avail), 0);
    check("R2 empty after drain", 32'(status[2:1]), 3);
  endtask

  task automatic t_rx();
    for (int i = 0; i < 16; i++) eng_push(8'h80 + 8'(i), 1'b0, 1'b0);
    settle();
    check("R4 data available", 32'(status[0]), 1);
    check("R4 half full", 32'(status[8]), 1);
    check("R5 no overrun yet", 32'(status[5]), 0);
    eng_push(8'hAA, 1'b0, 1'b0);
    settle();
    check("R5 overrun on drop", 32'(status[5]), 1);
    for (int i = 0; i < 16; i++) begin
      check("R4 rx order", 32'(bus_rx_data), 32'(8'h80 + 8'(i)));
      bus_read();
      if (i == 0) begin
        settle();
        check("R5 read clears overrun", 32'(status[5]), 0);
      end
      if (i == 7) begin
        settle();
        check("R4 half full at 8", 32'(status[8]), 1);
      end
      if (i == 8) begin
        settle();
        check("R4 half full clear at 7", 32'(status[8]), 0);
      end
    end
    settle();
    check("R5 dropped char absent", 32'(status[0]), 0);
  endtask

  task automatic t_err_flags();
    eng_push(8'h11, 1'b1, 1'b0);
    eng_push(8'h22, 1'b0, 1'b1);
    eng_push(8'h33, 1'b0, 1'b0);
    settle();
    check("R6 parity head", 32'(status[4:3]), 1);
    bus_read(); settle();
    check("R6 framing head", 32'(status[4:3]), 2);
    bus_read(); settle();
    check("R6 clean head", 32'(status[4:3]), 0);
    bus_read(); settle();
    check("R6 empty reads zero", 32'(status[4:3]), 0);
  endtask

  task automatic t_timeout();
    rx_tmo_val = 8'd5;
    eng_push(8'h55, 1'b0, 1'b0);
    for (int i = 0; i < 4; i++) tick();
    settle();
    check("R7 no timeout after 4 ticks", 32'(status[7]), 0);
    tick(); settle();
    check("R7 timeout after 5 ticks", 32'(status[7]), 1);
    bus_read(); settle();
    check("R7 read clears timeout", 32'(status[7]), 0);
    eng_push(8'h56, 1'b0, 1'b0);
    for (int i = 0; i < 3; i++) tick();
    eng_push(8'h57, 1'b0, 1'b0);
    for (int i = 0; i < 3; i++) tick();
    settle();
    check("R7 push restarts count", 32'(status[7]), 0);
    for (int i = 0; i < 2; i++) tick();
    settle();
    check("R7 timeout after restart", 32'(status[7]), 1);
    bus_read(); bus_read();
    rx_tmo_val = 8'd0;
    eng_push(8'h58, 1'b0, 1'b0);
    for (int i = 0; i < 10; i++) tick();
    settle();
    check("R7 zero disables timeout", 32'(status[7]), 0);
    bus_read(); settle();
  endtask

  task automatic t_flush();
    for (int i = 0; i < 5; i++) bus_write(8'h60 + 8'(i));
    for (int i = 0; i < 3; i++) eng_push(8'h70 + 8'(i), 1'b0, 1'b0);
    tx_flush = 1'b1; @(negedge clk); tx_flush = 1'b0;
    settle();
    check("R8 tx flushed", 32'(eng_tx_avail), 0);
    check("R8 tx empty flag", 32'(status[1]), 1);
    check("R8 rx untouched", 32'(bus_rx_data), 32'h70);
    rx_flush = 1'b1; @(negedge clk); rx_flush = 1'b0;
    settle();
    check("R8 rx flushed", 32'(status[0]), 0);
  endtask

  task automatic t_irq();
    int_enable = 9'h002; settle();
    check("R9 tx empty raises irq", 32'(irq), 1);
    int_enable = 9'h001; settle();
    check("R9 masked source", 32'(irq), 0);
    eng_push(8'h99, 1'b0, 1'b0); settle();
    check("R9 rx available raises irq", 32'(irq), 1);
    int_enable = 9'h040; settle();
    check("R9 reserved bit inert", 32'(irq), 0);
    bus_read();
    int_enable = '0; settle();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_tx();
    t_rx();
    t_err_flags();
    t_timeout();
    t_flush();
    t_irq();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_P * 100000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog (all requirements): actual hung expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule